// File: doc/BRIEF.md
# NOR Flash Array Controller with Stalling Bus

This block fronts an on-chip NOR-style storage array, modelled here as a synthesizable word RAM. The bus side is a request/ready interface. A single requester issues reads, programs of one, two or four bytes, and sector erases. Reads return a full 32-bit word one cycle after they are accepted. A program can only pull bits from 1 to 0: the stored word becomes the old contents ANDed with the new data. An erase restores one sector to all-ones.

A program or erase keeps the controller busy for a number of cycles set by parameters. During that time `req_ready` stays low, so any further request (read, program or erase) simply waits on the bus. It completes once the operation is done and no error is signalled. The sector map is uneven. It has four small sectors of one unit, then one sector of four units, then `NUM_BIG` sectors of eight units each. `UNIT_BYTES` sets the size of a unit. Erase time scales with sector size. A separate status port shows busy state and two sticky error flags at all times, whatever the bus is doing.

Top module: `nor_flash_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `stat_busy`, `stat_align_err` and `stat_sector_err` are 0, and every array word reads 0xFFFFFFFF.
- R2: A read (`req_op`=0) accepted while `req_ready` is 1 raises `rsp_valid` on the next cycle. `rsp_rdata` then holds the word at `req_addr[AW-1:2]`, with byte k on bits 8k+7:8k.
- R3: A program (`req_op`=1) takes its data from the byte lanes of `req_wdata` that `req_size` selects. Size 0 selects lane `req_addr[1:0]`. Size 1 selects lanes 1:0 when `req_addr[1]` is 0 and lanes 3:2 when it is 1. Size 2 selects all four lanes. In the selected lanes the stored value becomes old AND new. The other lanes are unchanged.
- R4: Program bits that would turn a stored 0 into 1 are ignored, and no error flag is raised.
- R5: A program whose address does not match its size is rejected: size 1 with `req_addr[0]`=1, size 2 with `req_addr[1:0]`≠0, or any size 3. The array is unchanged, the controller does not go busy, and `stat_align_err` is 1 on the next cycle and stays set.
- R6: A one-cycle pulse on `clr_align_err` or `clr_sector_err` clears the matching flag. If a new error is flagged in the same cycle, the set wins.
- R7: An accepted valid program holds `stat_busy` high and `req_ready` low for exactly `PROG_CYCLES` cycles, whatever its size.
- R8: An erase (`req_op`=2) takes its sector index from `req_addr`. Sectors 0–3 are 1 unit long, sector 4 is 4 units, and sectors 5 up to 4+`NUM_BIG` are 8 units each, laid out back to back from address 0. Every byte of the selected sector becomes 0xFF. Neighbouring sectors are unchanged.
- R9: An erase holds `stat_busy` high for exactly (sector units × `ERASE_CYC_PER_UNIT`) cycles.
- R10: An erase with an index of 5+`NUM_BIG` or more erases nothing and does not go busy. `stat_sector_err` is 1 on the next cycle.
- R11: A request presented while busy sees `req_ready` low until the operation ends. It is then accepted, and a stalled read returns the data as it stands after the operation.
- R12: The status port is never stalled: `stat_busy` is high in every cycle of an operation, including cycles in which a request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 no operation |
| req_addr | input | AW | Byte address, or the sector index for an erase |
| req_size | input | 2 | Program width: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Program data in its byte lanes |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data word |
| clr_align_err | input | 1 | Write-one-to-clear for the alignment flag |
| clr_sector_err | input | 1 | Write-one-to-clear for the sector flag |
| stat_busy | output | 1 | Program or erase in progress |
| stat_align_err | output | 1 | Sticky misaligned-program flag |
| stat_sector_err | output | 1 | Sticky bad-sector-index flag |

## Verification
Read data and both error flags are due one cycle after the accepting edge. The bench drives and samples on falling edges and reads them at the first falling edge after acceptance. Busy time is measured by counting the falling edges on which `stat_busy` is high, starting at that same point, and the count is compared with `PROG_CYCLES` or with units × `ERASE_CYC_PER_UNIT`. For a stalled request the bench counts the falling edges on which it saw `req_ready` low, and that count must equal the busy length of the operation ahead of it.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } state_e;

    // units per sector class; the map itself is computed in nfc_sector_map
    localparam int SMALL_SECTS = 4;
    localparam int MID_UNITS   = 4;
    localparam int BIG_UNITS   = 8;
endpackage

// File: rtl/nfc_sector_map.sv
module nfc_sector_map
    import nfc_pkg::*;
#(
    parameter int UNIT_WORDS         = 16,
    parameter int NUM_BIG            = 3,
    parameter int ERASE_CYC_PER_UNIT = 20,
    parameter int AW                 = 11,
    parameter int WW                 = 9,
    parameter int CW                 = 8
) (
    input  logic [AW-1:0] sect_idx,
    output logic          sect_ok,
    output logic [WW-1:0] sect_base,
    output logic [WW:0]   sect_words,
    output logic [CW-1:0] sect_cycles
);
    localparam int NUM_SECT = SMALL_SECTS + 1 + NUM_BIG;
    localparam int BIG_BASE = SMALL_SECTS + MID_UNITS;

    always_comb begin
        int idx;
        int base_u;
        int units;
        idx    = int'(sect_idx);
        sect_ok = (idx < NUM_SECT);
        if (idx < SMALL_SECTS) begin
            base_u = idx;
            units  = 1;
        end else if (idx == SMALL_SECTS) begin
            base_u = SMALL_SECTS;
            units  = MID_UNITS;
        end else if (sect_ok) begin
            base_u = BIG_BASE + (idx - SMALL_SECTS - 1) * BIG_UNITS;
            units  = BIG_UNITS;
        end else begin
            base_u = 0;
            units  = 1;
        end
        sect_base   = WW'(base_u * UNIT_WORDS);
        sect_words  = (WW+1)'(units * UNIT_WORDS);
        sect_cycles = CW'(units * ERASE_CYC_PER_UNIT);
    end
endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
    parameter int DEPTH = 512,
    parameter int WW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [WW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    input  logic          wr_en,
    input  logic          wr_erase,
    input  logic [WW-1:0] wr_addr,
    input  logic [3:0]    wr_lanes,
    input  logic [31:0]   wr_data
);
    logic [31:0] mem_q [DEPTH];
    logic [31:0] rd_q;
    logic [31:0] keep_mask;
    logic [31:0] cur_word;

    // lanes not selected contribute all-ones to the AND
    always_comb begin
        for (int b = 0; b < 4; b++) begin
            keep_mask[8*b +: 8] = wr_lanes[b] ? wr_data[8*b +: 8] : 8'hFF;
        end
    end

    assign cur_word = mem_q[wr_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
            rd_q <= '1;
        end else begin
            if (wr_en) begin
                if (wr_erase) mem_q[wr_addr] <= '1;
                else          mem_q[wr_addr] <= cur_word & keep_mask;
            end
            if (rd_en) rd_q <= mem_q[rd_addr];
        end
    end

    assign rd_data = rd_q;

    // R4
    prog_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_erase) |=> ((mem_q[$past(wr_addr)] & ~$past(cur_word)) == 32'h0));

    // R8
    erase_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_erase) |=> (mem_q[$past(wr_addr)] == 32'hFFFF_FFFF));
endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
    import nfc_pkg::*;
#(
    parameter int UNIT_BYTES         = 64,
    parameter int NUM_BIG            = 3,
    parameter int PROG_CYCLES        = 6,
    parameter int ERASE_CYC_PER_UNIT = 20,
    localparam int TOTAL_UNITS = SMALL_SECTS + MID_UNITS + BIG_UNITS * NUM_BIG,
    localparam int TOTAL_BYTES = TOTAL_UNITS * UNIT_BYTES,
    localparam int AW          = $clog2(TOTAL_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [31:0]   req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    input  logic          clr_align_err,
    input  logic          clr_sector_err,
    output logic          stat_busy,
    output logic          stat_align_err,
    output logic          stat_sector_err
);
    localparam int UNIT_WORDS = UNIT_BYTES / 4;
    localparam int DEPTH      = TOTAL_BYTES / 4;
    localparam int WW         = AW - 2;
    localparam int MAX_ERASE  = BIG_UNITS * ERASE_CYC_PER_UNIT;
    localparam int MAX_CYC    = (PROG_CYCLES > MAX_ERASE) ? PROG_CYCLES : MAX_ERASE;
    localparam int CW         = $clog2(MAX_CYC + 1);

    typedef struct packed {
        state_e        st;
        logic [CW-1:0] cnt;
        logic [WW-1:0] ptr;
        logic [WW:0]   left;
        logic          align_err;
        logic          sect_err;
        logic          rsp_valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    op_e           op;
    size_e         sz;
    logic          accept;
    logic          misaligned;
    logic [3:0]    lanes;
    logic          map_ok;
    logic [WW-1:0] map_base;
    logic [WW:0]   map_words;
    logic [CW-1:0] map_cycles;
    logic          rd_en;
    logic          wr_en;
    logic          wr_erase;
    logic [WW-1:0] wr_addr;

    assign op     = op_e'(req_op);
    assign sz     = size_e'(req_size);
    assign accept = req_valid && (ctl_q.st == ST_IDLE);

    nfc_sector_map #(
        .UNIT_WORDS        (UNIT_WORDS),
        .NUM_BIG           (NUM_BIG),
        .ERASE_CYC_PER_UNIT(ERASE_CYC_PER_UNIT),
        .AW                (AW),
        .WW                (WW),
        .CW                (CW)
    ) u_map (
        .sect_idx   (req_addr),
        .sect_ok    (map_ok),
        .sect_base  (map_base),
        .sect_words (map_words),
        .sect_cycles(map_cycles)
    );

    nfc_array #(
        .DEPTH(DEPTH),
        .WW   (WW)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (req_addr[AW-1:2]),
        .rd_data (rsp_rdata),
        .wr_en   (wr_en),
        .wr_erase(wr_erase),
        .wr_addr (wr_addr),
        .wr_lanes(lanes),
        .wr_data (req_wdata)
    );

    // lane selection and alignment check for a program request
    always_comb begin
        lanes      = 4'b0000;
        misaligned = 1'b0;
        unique case (sz)
            SZ_BYTE: lanes = 4'b0001 << req_addr[1:0];
            SZ_HALF: begin
                lanes      = req_addr[1] ? 4'b1100 : 4'b0011;
                misaligned = req_addr[0];
            end
            SZ_WORD: begin
                lanes      = 4'b1111;
                misaligned = (req_addr[1:0] != 2'b00);
            end
            default: misaligned = 1'b1;
        endcase
    end

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        rd_en           = 1'b0;
        wr_en           = 1'b0;
        wr_erase        = 1'b0;
        wr_addr         = req_addr[AW-1:2];
        if (clr_align_err)  ctl_d.align_err = 1'b0;
        if (clr_sector_err) ctl_d.sect_err  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (op)
                        OP_READ: begin
                            rd_en           = 1'b1;
                            ctl_d.rsp_valid = 1'b1;
                        end
                        OP_PROG: begin
                            if (misaligned) begin
                                ctl_d.align_err = 1'b1;
                            end else begin
                                wr_en     = 1'b1;
                                ctl_d.st  = ST_PROG;
                                ctl_d.cnt = CW'(PROG_CYCLES - 1);
                            end
                        end
                        OP_ERASE: begin
                            if (!map_ok) begin
                                ctl_d.sect_err = 1'b1;
                            end else begin
                                ctl_d.st   = ST_ERASE;
                                ctl_d.ptr  = map_base;
                                ctl_d.left = map_words;
                                ctl_d.cnt  = map_cycles - 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_PROG: begin
                if (ctl_q.cnt == '0) ctl_d.st  = ST_IDLE;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            ST_ERASE: begin
                if (ctl_q.left != '0) begin
                    wr_en      = 1'b1;
                    wr_erase   = 1'b1;
                    wr_addr    = ctl_q.ptr;
                    ctl_d.ptr  = ctl_q.ptr + 1'b1;
                    ctl_d.left = ctl_q.left - 1'b1;
                end
                if (ctl_q.cnt == '0) ctl_d.st  = ST_IDLE;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, ptr: '0, left: '0,
                       align_err: 1'b0, sect_err: 1'b0, rsp_valid: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready       = (ctl_q.st == ST_IDLE);
    assign rsp_valid       = ctl_q.rsp_valid;
    assign stat_busy       = (ctl_q.st != ST_IDLE);
    assign stat_align_err  = ctl_q.align_err;
    assign stat_sector_err = ctl_q.sect_err;

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(accept && op == OP_READ));

    // R5
    align_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_align_err) |-> $past(accept && op == OP_PROG && !stat_busy));

    // R5
    reject_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PROG && misaligned) |=> !stat_busy);

    // R10
    sect_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_sector_err) |-> $past(accept && op == OP_ERASE));

    // R9
    erase_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ERASE && ctl_q.cnt == '0) |-> (ctl_q.left <= 1));

    // R11
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_erase |-> stat_busy);

    // R7
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PROG && !misaligned) |=> (stat_busy && !req_ready));
endmodule

// File: tb/nor_flash_ctrl_test.sv
module nor_flash_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT_BYTES = 64;
    localparam int NUM_BIG    = 3;
    localparam int PROG_CYC   = 6;
    localparam int ECPU       = 20;
    localparam int AW         = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          clr_align_err = 1'b0;
    logic          clr_sector_err = 1'b0;
    logic          stat_busy;
    logic          stat_align_err;
    logic          stat_sector_err;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_flash_ctrl #(
        .UNIT_BYTES(UNIT_BYTES), .NUM_BIG(NUM_BIG),
        .PROG_CYCLES(PROG_CYC), .ERASE_CYC_PER_UNIT(ECPU)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .clr_align_err(clr_align_err), .clr_sector_err(clr_sector_err),
        .stat_busy(stat_busy), .stat_align_err(stat_align_err),
        .stat_sector_err(stat_sector_err)
    );

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    size;
        logic [31:0]   data;
        logic [31:0]   exp;
    } vec_t;

    // program, then read back the containing word
    localparam vec_t VEC [8] = '{
        '{addr: 11'h000, size: 2'd2, data: 32'h1234_5678, exp: 32'h1234_5678},
        '{addr: 11'h005, size: 2'd0, data: 32'h0000_AB00, exp: 32'hFFFF_ABFF},
        '{addr: 11'h00A, size: 2'd1, data: 32'h5A5A_0000, exp: 32'h5A5A_FFFF},
        '{addr: 11'h000, size: 2'd2, data: 32'hFFFF_00FF, exp: 32'h1234_0078},
        '{addr: 11'h000, size: 2'd2, data: 32'hFFFF_FFFF, exp: 32'h1234_0078},
        '{addr: 11'h007, size: 2'd0, data: 32'h0F00_0000, exp: 32'h0FFF_ABFF},
        '{addr: 11'h008, size: 2'd1, data: 32'h0000_C3C3, exp: 32'h5A5A_C3C3},
        '{addr: 11'h040, size: 2'd2, data: 32'hA5A5_A5A5, exp: 32'hA5A5_A5A5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic do_req(input logic [1:0] op, input logic [AW-1:0] addr,
                          input logic [1:0] size, input logic [31:0] data,
                          output int waits);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_size = size; req_wdata = data;
        waits = 0;
        while (!req_ready) begin
            if (!stat_busy) begin
                checks++; failures++;
                $display("FAIL R12 actual=busy0 expected=busy1 while stalled");
            end
            @(negedge clk);
            waits++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_op = 2'd3;
    endtask

    task automatic rd(input logic [AW-1:0] addr, output logic [31:0] word);
        int w;
        do_req(2'd0, addr, 2'd2, 32'h0, w);
        chk("R2 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        word = rsp_rdata;
    endtask

    task automatic prog(input logic [AW-1:0] addr, input logic [1:0] size,
                        input logic [31:0] data);
        int w;
        do_req(2'd1, addr, size, data, w);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (stat_busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end

    initial begin
        logic [31:0] word;
        int n;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", {31'h0, req_ready}, 32'h1);
        chk("R1 busy", {31'h0, stat_busy}, 32'h0);
        chk("R1 flags", {30'h0, stat_align_err, stat_sector_err}, 32'h0);
        rd(11'h100, word);
        chk("R1 erased word", word, 32'hFFFF_FFFF);

        // R3 R4 table of programs and readbacks
        foreach (VEC[i]) begin
            prog(VEC[i].addr, VEC[i].size, VEC[i].data);
            busy_len(n);
            rd({VEC[i].addr[AW-1:2], 2'b00}, word);
            chk(i == 3 || i == 4 ? "R4 and-only" : "R3 program", word, VEC[i].exp);
        end
        chk("R4 no flag", {30'h0, stat_align_err, stat_sector_err}, 32'h0);

        // R7 program duration for each size
        prog(11'h0C0, 2'd0, 32'h0);  busy_len(n); chk("R7 byte busy", n, PROG_CYC);
        prog(11'h0C2, 2'd1, 32'h0);  busy_len(n); chk("R7 half busy", n, PROG_CYC);
        prog(11'h0C4, 2'd2, 32'h0);  busy_len(n); chk("R7 word busy", n, PROG_CYC);

        // R5 misaligned programs
        prog(11'h00D, 2'd1, 32'h0);
        chk("R5 flag half", {31'h0, stat_align_err}, 32'h1);
        chk("R5 no busy", {31'h0, stat_busy}, 32'h0);
        @(negedge clk);
        prog(11'h00E, 2'd2, 32'h0);
        prog(11'h00C, 2'd3, 32'h0);
        rd(11'h00C, word);
        chk("R5 array unchanged", word, 32'hFFFF_FFFF);
        chk("R5 sticky", {31'h0, stat_align_err}, 32'h1);

        // R6 clear
        clr_align_err = 1'b1; @(negedge clk); clr_align_err = 1'b0;
        chk("R6 align cleared", {31'h0, stat_align_err}, 32'h0);

        // R11 R12 read stalled behind a program
        prog(11'h044, 2'd2, 32'h0000_0000);
        do_req(2'd0, 11'h044, 2'd2, 32'h0, w);
        chk("R11 read wait", w, PROG_CYC);
        chk("R11 read data", rsp_rdata, 32'h0);

        // R11 erase stalled behind a program; prepare neighbours
        prog(11'h07C, 2'd2, 32'h0);
        prog(11'h080, 2'd2, 32'h0);
        do_req(2'd2, 11'd1, 2'd0, 32'h0, w);
        chk("R11 erase wait", w, PROG_CYC);
        busy_len(n);
        chk("R9 small erase busy", n, ECPU);
        rd(11'h040, word); chk("R8 sector1 first", word, 32'hFFFF_FFFF);
        rd(11'h07C, word); chk("R8 sector1 last", word, 32'hFFFF_FFFF);
        rd(11'h000, word); chk("R8 sector0 kept", word, 32'h1234_0078);
        rd(11'h080, word); chk("R8 sector2 kept", word, 32'h0);

        // R8 R9 mid sector (index 4, bytes 0x100..0x1FF)
        prog(11'h1FC, 2'd2, 32'h0); busy_len(n);
        prog(11'h200, 2'd2, 32'h0); busy_len(n);
        do_req(2'd2, 11'd4, 2'd0, 32'h0, w);
        busy_len(n);
        chk("R9 mid erase busy", n, 4 * ECPU);
        rd(11'h1FC, word); chk("R8 mid erased", word, 32'hFFFF_FFFF);
        rd(11'h200, word); chk("R8 big kept", word, 32'h0);

        // R8 R9 last big sector (index 7, bytes 0x600..0x7FF)
        prog(11'h7FC, 2'd2, 32'h0); busy_len(n);
        prog(11'h5FC, 2'd2, 32'h0); busy_len(n);
        do_req(2'd2, 11'd7, 2'd0, 32'h0, w);
        busy_len(n);
        chk("R9 big erase busy", n, 8 * ECPU);
        rd(11'h7FC, word); chk("R8 big erased", word, 32'hFFFF_FFFF);
        rd(11'h5FC, word); chk("R8 prev big kept", word, 32'h0);

        // R10 bad sector index
        do_req(2'd2, 11'd8, 2'd0, 32'h0, w);
        chk("R10 flag", {31'h0, stat_sector_err}, 32'h1);
        chk("R10 no busy", {31'h0, stat_busy}, 32'h0);
        rd(11'h200, word); chk("R10 nothing erased", word, 32'h0);

        // R6 sector clear, and set wins over clear
        clr_sector_err = 1'b1; @(negedge clk); clr_sector_err = 1'b0;
        chk("R6 sector cleared", {31'h0, stat_sector_err}, 32'h0);
        clr_align_err = 1'b1;
        prog(11'h001, 2'd1, 32'h0);
        clr_align_err = 1'b0;
        chk("R6 set wins", {31'h0, stat_align_err}, 32'h1);

        finish_up();
    end
endmodule